// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Port

This block is a serial peripheral port that moves one byte at a time over a four-wire SPI bus. It works either as the bus master, where it makes the serial clock from the system clock and drives chip select, or as a bus slave, where it follows a serial clock and chip select from another device. Software sets it up and moves data through a small register port. There are four registers: control, format, data and status.

In master mode, a write to the data register loads the shift buffer and starts the transfer at once. In slave mode, the loaded byte waits in the shift buffer until an external master clocks it out. In both modes the received byte reaches the readable data register only after its last bit has arrived. At that point a completion flag is set, and that flag drives the interrupt output. Every bus line has an output-enable signal, so a pad wrapper can model tristate behaviour.

Register map (two address bits). Address 0 is control: bits [1:0] mode, bit 2 clock-source select, bit 3 chip-select enable, bit 4 port enable. Address 1 is format: bit 0 clock polarity, bit 1 LSB-first. Address 2 is data. Address 3 is status: bit 0 byte done, bit 1 write collision. Writing a 1 to a status bit clears it.

Top module: `spi_port`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and `sckOe`, `scsOe` and `sdoOe` are all low.
- R2: While control bit 4 is 0, the port drives none of its lines: `sckOe`, `scsOe` and `sdoOe` are all 0.
- R3: When the port is enabled and idle, `sdoOe` is 1 and `sdoOut` is 1. In master mode `sckOe` is 1 and `sckOut` equals format bit 0. In slave mode (mode 11) `sckOe` is 0.
- R4: Modes 00, 01 and 10 are master modes. Each bit takes 2·H system cycles. H is 2, 8 and 32 for the three modes, and it is multiplied by 4 when control bit 2 is 1. `irq` rises exactly 16·H cycles after the clock edge that captures the data write.
- R5: Format bit 1 set to 0 shifts MSB first and set to 1 shifts LSB first, in both directions. Input is sampled on the leading SCK edge (the move away from the polarity level). SDO changes on the trailing edge. The first bit is on SDO before the first edge.
- R6: A read of the data register during a transfer returns the previously completed byte. The new byte appears only when all of its bits are in.
- R7: A data write while a master transfer runs sets status bit 1. It leaves the byte being sent and the byte being received unchanged.
- R8: Status bit 0 and `irq` are set at the end of every complete byte. They stay set until software writes 1 to status bit 0.
- R9: When control bit 3 is 1, a master drives `scsOut` low with `scsOe` high for the whole transfer. When it is 0, `scsOe` is 0 and a slave shifts regardless of `scsIn`.
- R10: In slave mode the port shifts on the synchronised `sckIn` edges while chip select is active. Control bit 2 has no effect on the result.
- R11: In slave mode with chip select enabled, `scsIn` going high in the middle of a byte drops that byte. No completion flag is set, the data register is unchanged, and the next full byte is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Byte-complete interrupt request |
| sckIn | input | 1 | Serial clock from pad |
| sckOut | output | 1 | Serial clock to pad |
| sckOe | output | 1 | Serial clock output enable |
| scsIn | input | 1 | Chip select from pad (active low) |
| scsOut | output | 1 | Chip select to pad |
| scsOe | output | 1 | Chip select output enable |
| sdiIn | input | 1 | Serial data in |
| sdoOut | output | 1 | Serial data out |
| sdoOe | output | 1 | Serial data output enable |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, master dividers of 4, 16 and 64, a prescaler of 4, and two synchroniser stages. With these values every rate and prescaler combination fits in a short run; the slowest master byte is 2048 cycles. This allows an exact cycle count from data write to interrupt for each combination. A bench-side slave model checks bit order in both directions. A bench-side master, with a half period of eight cycles, drives slave transfers, a chip-select abort and transfers with chip select ignored, while leaving margin for the synchroniser latency.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {
    MODE_FAST  = 2'b00,
    MODE_MID   = 2'b01,
    MODE_SLOW  = 2'b10,
    MODE_SLAVE = 2'b11
  } spiMode_e;

  // Strobes from control to the shift datapath
  typedef struct packed {
    logic load;    // take a new byte from the register port
    logic sample;  // capture serial input (leading edge)
    logic shift;   // advance the buffer (trailing edge)
    logic commit;  // copy the completed byte to the read register
  } shiftStrobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FMT  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
  parameter int RATE0_DIV = 4,
  parameter int RATE1_DIV = 16,
  parameter int RATE2_DIV = 64,
  parameter int PRE_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic [1:0] rateSel,
  input  logic       preSel,
  output logic       tick
);
  localparam int MAX_HALF = (RATE2_DIV / 2) * PRE_DIV;
  localparam int CNT_W = $clog2(MAX_HALF + 1);

  logic [CNT_W-1:0] baseHalf, halfLen, cnt;
  logic wrap;

  always_comb begin
    case (rateSel)
      2'd0:    baseHalf = CNT_W'(RATE0_DIV / 2);
      2'd1:    baseHalf = CNT_W'(RATE1_DIV / 2);
      default: baseHalf = CNT_W'(RATE2_DIV / 2);
    endcase
    halfLen = preSel ? CNT_W'(baseHalf * PRE_DIV) : baseHalf;
  end

  assign wrap = (cnt == halfLen - CNT_W'(1));
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (wrap)      cnt <= '0;
    else                cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobe_t      stb,
  input  logic [DATA_W-1:0] loadData,
  input  logic              lsbFirst,
  input  logic              serialIn,
  output logic              curBit,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] shiftReg, shiftNext;
  logic sampleBit;

  assign shiftNext = lsbFirst ? {sampleBit, shiftReg[DATA_W-1:1]}
                              : {shiftReg[DATA_W-2:0], sampleBit};
  assign curBit = lsbFirst ? shiftReg[0] : shiftReg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      sampleBit <= 1'b0;
      rxData    <= '0;
    end else begin
      if (stb.load)        shiftReg <= loadData;
      else if (stb.shift)  shiftReg <= shiftNext;
      if (stb.sample)      sampleBit <= serialIn;
      if (stb.commit)      rxData <= shiftNext;
    end
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              tick,
  output logic              run,
  output logic [1:0]        rateSel,
  output logic              preSel,
  input  logic              sckS,
  input  logic              scsS,
  input  logic              sdiS,
  input  logic              sdiIn,
  input  logic              curBit,
  input  logic [DATA_W-1:0] rxData,
  output shiftStrobe_t      stb,
  output logic [DATA_W-1:0] loadData,
  output logic              lsbFirst,
  output logic              serialIn,
  output logic              sckOut,
  output logic              sckOe,
  output logic              scsOut,
  output logic              scsOe,
  output logic              sdoOut,
  output logic              sdoOe,
  output logic              irq,
  output logic              portEn,
  output logic              isMaster,
  output logic              busy,
  output logic              wcolFlag
);
  localparam int BIT_W = $clog2(DATA_W);

  spiMode_e modeR;
  logic clkSrcR, csEnR, enR, polR, lsbR, doneR, wcolR;
  logic xferOn, phase, sckPrev;
  logic [BIT_W-1:0] bitCnt;

  logic wrCtrl, wrFmt, wrData, wrStat;
  logic slaveOn, slaveSel, sckMoved;
  logic lead, trail, lastBit, finish, abortByte, collide;

  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign wrFmt  = regWrEn && (regAddr == ADDR_FMT);
  assign wrData = regWrEn && (regAddr == ADDR_DATA);
  assign wrStat = regWrEn && (regAddr == ADDR_STAT);

  assign isMaster = (modeR != MODE_SLAVE);
  assign slaveOn  = enR && !isMaster;
  assign slaveSel = !csEnR || !scsS;
  assign sckMoved = (sckS != sckPrev);

  always_comb begin
    if (isMaster) begin
      lead  = tick && !phase;
      trail = tick && phase;
    end else begin
      lead  = slaveOn && slaveSel && sckMoved && (sckPrev == polR);
      trail = slaveOn && slaveSel && sckMoved && (sckPrev != polR);
    end
  end

  assign lastBit   = (bitCnt == BIT_W'(DATA_W - 1));
  assign finish    = trail && lastBit;
  assign abortByte = slaveOn && csEnR && scsS && (bitCnt != '0);
  assign busy      = isMaster ? xferOn : (bitCnt != '0);
  assign collide   = wrData && busy;

  assign stb.load   = wrData && !busy;
  assign stb.sample = lead;
  assign stb.shift  = trail;
  assign stb.commit = finish;
  assign loadData   = regWdata;
  assign lsbFirst   = lsbR;
  assign serialIn   = isMaster ? sdiIn : sdiS;

  assign run     = xferOn;
  assign rateSel = modeR;
  assign preSel  = clkSrcR;

  // Bus-side drive
  assign sckOut = polR ^ phase;
  assign sckOe  = enR && isMaster;
  assign scsOut = !xferOn;
  assign scsOe  = enR && csEnR && isMaster;
  assign sdoOut = (isMaster ? xferOn : slaveSel) ? curBit : 1'b1;
  assign sdoOe  = enR;

  assign irq      = doneR;
  assign portEn   = enR;
  assign wcolFlag = wcolR;

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdata = {{(DATA_W-5){1'b0}}, enR, csEnR, clkSrcR, modeR};
      ADDR_FMT:  regRdata = {{(DATA_W-2){1'b0}}, lsbR, polR};
      ADDR_DATA: regRdata = rxData;
      default:   regRdata = {{(DATA_W-2){1'b0}}, wcolR, doneR};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR   <= MODE_FAST;
      clkSrcR <= 1'b0;
      csEnR   <= 1'b0;
      enR     <= 1'b0;
      polR    <= 1'b0;
      lsbR    <= 1'b0;
      doneR   <= 1'b0;
      wcolR   <= 1'b0;
      xferOn  <= 1'b0;
      phase   <= 1'b0;
      sckPrev <= 1'b0;
      bitCnt  <= '0;
    end else begin
      sckPrev <= sckS;
      if (wrCtrl) begin
        modeR   <= spiMode_e'(regWdata[1:0]);
        clkSrcR <= regWdata[2];
        csEnR   <= regWdata[3];
        enR     <= regWdata[4];
      end
      if (wrFmt) begin
        polR <= regWdata[0];
        lsbR <= regWdata[1];
      end
      if (wrData && !busy && isMaster && enR) begin
        xferOn <= 1'b1;
        phase  <= 1'b0;
        bitCnt <= '0;
      end
      if (tick) phase <= !phase;
      if (trail) begin
        bitCnt <= lastBit ? '0 : bitCnt + BIT_W'(1);
        if (lastBit && isMaster) xferOn <= 1'b0;
      end
      if (abortByte) bitCnt <= '0;
      if (finish)                       doneR <= 1'b1;
      else if (wrStat && regWdata[0])   doneR <= 1'b0;
      if (collide)                      wcolR <= 1'b1;
      else if (wrStat && regWdata[1])   wcolR <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE0_DIV = 4,
  parameter int RATE1_DIV = 16,
  parameter int RATE2_DIV = 64,
  parameter int PRE_DIV = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              scsIn,
  output logic              scsOut,
  output logic              scsOe,
  input  logic              sdiIn,
  output logic              sdoOut,
  output logic              sdoOe
);
  shiftStrobe_t stb;
  logic [DATA_W-1:0] loadData, rxData;
  logic sckS, scsS, sdiS, tick, run, preSel, lsbFirst, serialIn, curBit;
  logic portEn, isMaster, busy, wcolFlag;
  logic [1:0] rateSel;

  spi_port_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_sckSync (
    .clk(clk), .rstN(rstN), .din(sckIn), .dout(sckS));

  spi_port_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b11)) u_linkSync (
    .clk(clk), .rstN(rstN), .din({scsIn, sdiIn}), .dout({scsS, sdiS}));

  spi_port_clkgen #(.RATE0_DIV(RATE0_DIV), .RATE1_DIV(RATE1_DIV),
                    .RATE2_DIV(RATE2_DIV), .PRE_DIV(PRE_DIV)) u_clkgen (
    .clk(clk), .rstN(rstN), .run(run), .rateSel(rateSel), .preSel(preSel), .tick(tick));

  spi_port_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .tick(tick), .run(run), .rateSel(rateSel), .preSel(preSel),
    .sckS(sckS), .scsS(scsS), .sdiS(sdiS), .sdiIn(sdiIn), .curBit(curBit), .rxData(rxData),
    .stb(stb), .loadData(loadData), .lsbFirst(lsbFirst), .serialIn(serialIn),
    .sckOut(sckOut), .sckOe(sckOe), .scsOut(scsOut), .scsOe(scsOe),
    .sdoOut(sdoOut), .sdoOe(sdoOe), .irq(irq), .portEn(portEn), .isMaster(isMaster),
    .busy(busy), .wcolFlag(wcolFlag));

  spi_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadData(loadData), .lsbFirst(lsbFirst),
    .serialIn(serialIn), .curBit(curBit), .rxData(rxData));
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [1:0] regAddr,
  input logic [7:0] regWdata,
  input logic       irq,
  input logic       sckOe,
  input logic       scsOe,
  input logic       sdoOe,
  input logic       sdoOut,
  input logic       portEn,
  input logic       isMaster,
  input logic       busy,
  input logic       wcolFlag
);
  // R2
  disabled_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |-> !(sckOe || scsOe || sdoOe));

  // R3
  sdo_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    portEn && isMaster && !busy |-> sdoOut);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq && !(regWrEn && regAddr == 2'd3 && regWdata[0]) |=> irq);

  // R8
  irq_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(busy));

  // R8
  master_end_sets_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    isMaster && $fell(busy) |-> irq);

  // R7
  wcol_on_busy_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    isMaster && busy && regWrEn && regAddr == 2'd2 |=> wcolFlag);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata[7:0]),
  .irq(irq), .sckOe(sckOe), .scsOe(scsOe), .sdoOe(sdoOe), .sdoOut(sdoOut),
  .portEn(portEn), .isMaster(isMaster), .busy(busy), .wcolFlag(wcolFlag));

// File: tb/spi_port_tb.sv
module spi_port_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, regWrEn, sckIn, scsIn, sdiIn;
  logic [1:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic irq, sckOut, sckOe, scsOut, scsOe, sdoOut, sdoOe;

  spi_port u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .scsIn(scsIn), .scsOut(scsOut), .scsOe(scsOe), .sdiIn(sdiIn), .sdoOut(sdoOut),
    .sdoOe(sdoOe));

  typedef struct packed {
    logic [1:0] mode;
    logic       pre;
    logic       lsb;
    logic       pol;
    logic [7:0] tx;   // byte the port sends
    logic [7:0] rx;   // byte the far side sends
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
    '{2'd1, 1'b1, 1'b1, 1'b0, 8'h1E, 8'hC3},
    '{2'd2, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h81},
    '{2'd2, 1'b1, 1'b1, 1'b1, 8'hF0, 8'h07},
    '{2'd0, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF},
    '{2'd1, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h00},
    '{2'd3, 1'b0, 1'b0, 1'b0, 8'h6D, 8'hB2},
    '{2'd3, 1'b1, 1'b1, 1'b1, 8'h2B, 8'hD4}
  };

  int nChk = 0;
  int nFail = 0;
  bit doneFlag = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  function automatic logic bitOf(input logic [7:0] b, input int k, input logic lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  // Far-side slave for master transfers
  task automatic slaveModel(input logic [7:0] slv, input logic lsb, input logic pol,
                            output logic [7:0] cap, output logic scsGood);
    logic prev;
    int k;
    prev = pol; k = 0; cap = '0; scsGood = 1'b1;
    sdiIn = bitOf(slv, 0, lsb);
    while (k < 8) begin
      @(negedge clk);
      if (sckOut !== prev) begin
        if (prev == pol) begin
          if (lsb) cap[k] = sdoOut; else cap[7-k] = sdoOut;
          if (!(scsOe && !scsOut)) scsGood = 1'b0;
        end else begin
          k++;
          if (k < 8) sdiIn = bitOf(slv, k, lsb);
        end
        prev = sckOut;
      end
    end
  endtask

  // Far-side master for slave transfers, half period 8 cycles
  task automatic benchMaster(input logic [7:0] snd, input logic lsb, input logic pol,
                             input int nBits, input logic useScs, output logic [7:0] cap);
    cap = '0;
    if (useScs) scsIn = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nBits; k++) begin
      sdiIn = bitOf(snd, k, lsb);
      repeat (8) @(negedge clk);
      if (lsb) cap[k] = sdoOut; else cap[7-k] = sdoOut;
      sckIn = ~pol;
      repeat (8) @(negedge clk);
      sckIn = pol;
    end
    repeat (8) @(negedge clk);
    scsIn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (!irq && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runVector(input vec_t v, input int idx);
    logic [7:0] cap, d;
    logic scsGood;
    int n, h;
    regWrite(2'd1, {6'b0, v.lsb, v.pol});
    if (v.mode != 2'd3) begin
      regWrite(2'd0, {3'b0, 1'b1, 1'b1, v.pre, v.mode});
      h = (v.mode == 2'd0) ? 2 : (v.mode == 2'd1) ? 8 : 32;
      if (v.pre) h = h * 4;
      fork
        slaveModel(v.rx, v.lsb, v.pol, cap, scsGood);
        begin
          regWrite(2'd2, v.tx);
          waitIrq(n);
        end
      join
      chk($sformatf("R4 byte time vec%0d", idx), n, 16 * h);
      chk($sformatf("R5 sent order vec%0d", idx), cap, v.tx);
      chk($sformatf("R9 scs active vec%0d", idx), scsGood, 1);
    end else begin
      sckIn = v.pol; scsIn = 1'b1;
      repeat (4) @(negedge clk);
      regWrite(2'd0, {3'b0, 1'b1, 1'b1, v.pre, 2'b11});
      regWrite(2'd2, v.tx);
      benchMaster(v.rx, v.lsb, v.pol, 8, 1'b1, cap);
      chk($sformatf("R10 slave sent vec%0d", idx), cap, v.tx);
    end
    regRead(2'd2, d);
    chk($sformatf("R5 received vec%0d", idx), d, v.rx);
    regRead(2'd3, d);
    chk($sformatf("R8 done flag vec%0d", idx), d[0], 1);
    regWrite(2'd3, 8'h01);
    @(negedge clk);
    chk($sformatf("R8 cleared vec%0d", idx), irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, prevData, cap;
    logic scsGood;
    int n;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWdata = '0;
    sckIn = 1'b0; scsIn = 1'b1; sdiIn = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 oe after reset", {sckOe, scsOe, sdoOe}, 0);
    chk("R1 irq after reset", irq, 0);
    rstN = 1'b1;
    regRead(2'd0, d); chk("R1 ctrl reset", d, 0);
    regRead(2'd2, d); chk("R1 data reset", d, 0);
    regRead(2'd3, d); chk("R1 stat reset", d, 0);

    // R3 idle levels
    regWrite(2'd1, 8'h01);
    regWrite(2'd0, 8'h18);
    @(negedge clk);
    chk("R3 master sck drive", {sckOe, sckOut}, 2'b11);
    chk("R3 sdo idle high", {sdoOe, sdoOut}, 2'b11);
    chk("R3 scs idle high", {scsOe, scsOut}, 2'b11);
    sckIn = 1'b1;
    repeat (4) @(negedge clk);
    regWrite(2'd0, 8'h1B);
    @(negedge clk);
    chk("R3 slave sck input", sckOe, 0);
    chk("R3 slave sdo idle", {sdoOe, sdoOut}, 2'b11);

    for (int i = 0; i < NVEC; i++) runVector(VECS[i], i);

    // R6 / R7 collision during a slow master byte
    regWrite(2'd1, 8'h00);
    regWrite(2'd0, 8'h1A);
    regRead(2'd2, prevData);
    fork
      slaveModel(8'h99, 1'b0, 1'b0, cap, scsGood);
      begin
        regWrite(2'd2, 8'h3C);
        repeat (50) @(negedge clk);
        regWrite(2'd2, 8'hFF);
        regRead(2'd2, d);
        chk("R6 data held mid-byte", d, prevData);
        regRead(2'd3, d);
        chk("R7 collision flag", d[1], 1);
        waitIrq(n);
      end
    join
    chk("R7 sent byte intact", cap, 8'h3C);
    regRead(2'd2, d);
    chk("R7 received byte intact", d, 8'h99);
    regWrite(2'd3, 8'h03);
    regRead(2'd3, d);
    chk("R8 flags cleared", d, 0);

    // R11 slave abort then full byte
    sckIn = 1'b0;
    regWrite(2'd0, 8'h1B);
    regWrite(2'd2, 8'h11);
    regRead(2'd2, prevData);
    benchMaster(8'hAA, 1'b0, 1'b0, 3, 1'b1, cap);
    chk("R11 no done on abort", irq, 0);
    regRead(2'd2, d);
    chk("R11 data unchanged on abort", d, prevData);
    regWrite(2'd2, 8'h11);
    benchMaster(8'h5C, 1'b0, 1'b0, 8, 1'b1, cap);
    regRead(2'd2, d);
    chk("R11 byte after abort", d, 8'h5C);
    chk("R11 sent after abort", cap, 8'h11);
    regWrite(2'd3, 8'h01);

    // R9 chip select disabled
    regWrite(2'd0, 8'h10);
    @(negedge clk);
    chk("R9 master scs released", scsOe, 0);
    regWrite(2'd0, 8'h13);
    regWrite(2'd2, 8'h77);
    scsIn = 1'b1;
    benchMaster(8'h4E, 1'b0, 1'b0, 8, 1'b0, cap);
    regRead(2'd2, d);
    chk("R9 slave ignores scs", d, 8'h4E);
    chk("R9 slave sent ignoring scs", cap, 8'h77);
    regWrite(2'd3, 8'h01);

    // R2 disabled port
    regWrite(2'd0, 8'h08);
    @(negedge clk);
    chk("R2 no drive when disabled", {sckOe, scsOe, sdoOe}, 0);

    doneFlag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule